// File: doc/BRIEF.md
# Period and pulse-width capture unit

This block measures a digital signal that is asynchronous to the block clock. A free-running counter timestamps the edges of the signal. One edge direction is the restart edge. On a restart edge the counter value is taken as the period, and the counter starts again. On the edge in the other direction the counter value is taken as the pulse width. Both values are in clock cycles. A routing select chooses which of the two capture registers receives the period. The other register receives the width. An invert select chooses whether the restart edge is the rising edge or the falling edge.

Each capture register has a per-channel enable and a capture flag. The flag shows that the register holds a value nobody has collected yet. The reader clears a flag with a one-cycle strobe. If a capture arrives for a channel whose flag is still set, the new value is dropped and a sticky overrun error flag is raised. Software derives frequency and duty cycle from the two values. That arithmetic is outside this block.

A small phase state machine tracks the signal. It has three states:
- `ST_IDLE`: no restart edge has been seen since reset.
- `ST_FIRST`: the signal is between a restart edge and the opposite edge.
- `ST_SECOND`: the signal is between the opposite edge and the next restart edge.

It has three transitions:
- Start: `ST_IDLE` to `ST_FIRST` on a restart edge. The counter is loaded and nothing is captured.
- Width: `ST_FIRST` to `ST_SECOND` on the opposite edge. The width is captured.
- Period: `ST_FIRST` or `ST_SECOND` to `ST_FIRST` on a restart edge. The period is captured and the counter is reloaded.

Top module: `pulse_meter`

## Requirements
- R1: After reset both capture registers read 0, both capture flags are 0 and the overrun error flag is 0.
- R2: With `width_first` = 0, `cap0` receives the period and `cap1` receives the width. The period is the number of clock cycles between two successive restart edges. The width is the number of clock cycles from a restart edge to the following opposite edge. Each is exact for an input that holds each level for at least one clock cycle, because the counter is loaded with 1 on the restart cycle.
- R3: With `width_first` = 1 the routing is swapped: `cap0` receives the width and `cap1` receives the period.
- R4: With `wrap_on_fall` = 0 the restart edge is the rising edge, so the width is the high time. With `wrap_on_fall` = 1 the restart edge is the falling edge, so the width is the low time.
- R5: Edges seen before the first restart edge after reset produce no capture. The first restart edge itself produces no capture.
- R6: Bit 0 of `cap_en` enables channel 0 (`cap0`) and bit 1 enables channel 1 (`cap1`); the value 3 enables both. A disabled channel's register is not written and its flag is not set.
- R7: A capture for an enabled channel whose flag is set, with no clear strobe for that channel in the same cycle, leaves the register unchanged and sets `overrun_err`.
- R8: A `flag_clr` bit clears the matching flag. If a capture and a clear for the same channel fall in the same cycle, the register is written, the flag stays 1 and no error is raised.
- R9: `overrun_err` stays set until `err_clr` is pulsed. The pulse clears it and leaves the capture flags untouched.
- R10: The counter stops at its maximum value 2^CNT_W-1 while no restart edge occurs, so a period or width longer than that is captured as the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Signal under measurement, asynchronous |
| width_first | input | 1 | 0: period to cap0, width to cap1; 1: swapped |
| wrap_on_fall | input | 1 | 0: restart on rising edge; 1: restart on falling edge |
| cap_en | input | 2 | Per-channel capture enable, bit n for channel n |
| flag_clr | input | 2 | One-cycle clear strobe for each capture flag |
| err_clr | input | 1 | One-cycle clear strobe for the overrun error flag |
| cap0 | output | CNT_W | Capture register of channel 0 |
| cap1 | output | CNT_W | Capture register of channel 1 |
| cap_flag | output | 2 | Capture flags, bit n for channel n |
| overrun_err | output | 1 | Sticky capture overrun error |

## Verification
The bench builds the block with CNT_W = 6, so the counter saturates at 63. A saturating period and width can therefore be produced within about eighty cycles. This makes R10 reachable next to the main sweep. The sweep covers every high time and low time from 1 to 5 cycles, under all four combinations of routing and invert select. Expected values come from the high and low times alone. Directed sequences then cover:
- the ignored early edges,
- a disabled channel,
- an overrun,
- a capture that coincides with its clear strobe.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int unsigned NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } ph_state_t;

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_async,
    input  logic invert,
    output logic wrap_pulse,
    output logic opp_pulse
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;
    logic                   level;
    logic                   rise;
    logic                   fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], sig_async};
            last_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        level      = chain_q[SYNC_STAGES-1];
        rise       = level & ~last_q;
        fall       = ~level & last_q;
        wrap_pulse = invert ? fall : rise;
        opp_pulse  = invert ? rise : fall;
    end
endmodule

// File: rtl/pm_phase_fsm.sv
module pm_phase_fsm
    import pm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_pulse,
    input  logic opp_pulse,
    output logic restart,
    output logic run,
    output logic take_period,
    output logic take_width
);
    ph_state_t state_q;
    ph_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wrap_pulse) state_d = ST_FIRST;
            ST_FIRST:  if (wrap_pulse) state_d = ST_FIRST;
                       else if (opp_pulse) state_d = ST_SECOND;
            ST_SECOND: if (wrap_pulse) state_d = ST_FIRST;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        restart     = wrap_pulse;
        run         = 1'b0;
        take_period = 1'b0;
        take_width  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run = 1'b0;
            end
            ST_FIRST: begin
                run         = 1'b1;
                take_period = wrap_pulse;
                take_width  = opp_pulse & ~wrap_pulse;
            end
            ST_SECOND: begin
                run         = 1'b1;
                take_period = wrap_pulse;
            end
            default: begin
                restart = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (restart)                 cnt_q <= CNT_ONE;
        else if (run && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end
endmodule

// File: rtl/pm_channel.sv
module pm_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_strobe,
    input  logic             enable,
    input  logic             clr,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] data_q,
    output logic             flag_q,
    output logic             overrun
);
    logic write;

    always_comb begin
        write   = cap_strobe & enable;
        overrun = write & flag_q & ~clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (write && !overrun) data_q <= value;
            if (write)             flag_q <= 1'b1;
            else if (clr)          flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import pm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             width_first,
    input  logic             wrap_on_fall,
    input  logic [1:0]       cap_en,
    input  logic [1:0]       flag_clr,
    input  logic             err_clr,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1,
    output logic [1:0]       cap_flag,
    output logic             overrun_err
);
    logic             wrap_pulse;
    logic             opp_pulse;
    logic             restart;
    logic             run;
    logic             take_period;
    logic             take_width;
    logic [CNT_W-1:0] cnt_val;
    logic [NUM_CH-1:0] ch_strobe;
    logic [NUM_CH-1:0] ch_ovr;
    logic [CNT_W-1:0] ch_data [NUM_CH];
    logic             err_q;

    pm_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_async  (sig_in),
        .invert     (wrap_on_fall),
        .wrap_pulse (wrap_pulse),
        .opp_pulse  (opp_pulse)
    );

    pm_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_pulse  (wrap_pulse),
        .opp_pulse   (opp_pulse),
        .restart     (restart),
        .run         (run),
        .take_period (take_period),
        .take_width  (take_width)
    );

    pm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .cnt_q   (cnt_val)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == 0) begin : g_route
            assign ch_strobe[g] = width_first ? take_width : take_period;
        end else begin : g_route
            assign ch_strobe[g] = width_first ? take_period : take_width;
        end

        pm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cap_strobe (ch_strobe[g]),
            .enable     (cap_en[g]),
            .clr        (flag_clr[g]),
            .value      (cnt_val),
            .data_q     (ch_data[g]),
            .flag_q     (cap_flag[g]),
            .overrun    (ch_ovr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (|ch_ovr)  err_q <= 1'b1;
        else if (err_clr)  err_q <= 1'b0;
    end

    assign cap0        = ch_data[0];
    assign cap1        = ch_data[1];
    assign overrun_err = err_q;
endmodule

// File: rtl/pulse_meter_chk.sv
module pulse_meter_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cap_en,
    input logic [1:0]       flag_clr,
    input logic             err_clr,
    input logic [CNT_W-1:0] cap0,
    input logic [CNT_W-1:0] cap1,
    input logic [1:0]       cap_flag,
    input logic             overrun_err,
    input logic [CNT_W-1:0] cnt,
    input logic             restart
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_RESTART_LOADS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == CNT_ONE); // R2
    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !restart) |=> cnt == CNT_MAX); // R10
    AST_CH0_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en[0] |=> ($stable(cap0) && !$rose(cap_flag[0]))); // R6
    AST_CH1_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en[1] |=> ($stable(cap1) && !$rose(cap_flag[1]))); // R6
    AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag[0] && !flag_clr[0]) |=> cap_flag[0]); // R8
    AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag[1] && !flag_clr[1]) |=> cap_flag[1]); // R8
    AST_ERR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(cap_flag != 2'b00)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && !err_clr) |=> overrun_err); // R9
endmodule

bind pulse_meter pulse_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .flag_clr    (flag_clr),
    .err_clr     (err_clr),
    .cap0        (cap0),
    .cap1        (cap1),
    .cap_flag    (cap_flag),
    .overrun_err (overrun_err),
    .cnt         (cnt_val),
    .restart     (restart)
);

// File: tb/pulse_meter_bench.sv
module pulse_meter_bench;
    localparam int unsigned CNT_W = 6;
    localparam int          CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_in = 1'b0;
    logic             width_first = 1'b0;
    logic             wrap_on_fall = 1'b0;
    logic [1:0]       cap_en = 2'b11;
    logic [1:0]       flag_clr = 2'b00;
    logic             err_clr = 1'b0;
    logic [CNT_W-1:0] cap0;
    logic [CNT_W-1:0] cap1;
    logic [1:0]       cap_flag;
    logic             overrun_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pulse_meter #(.CNT_W(CNT_W)) u_pulse_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_in       (sig_in),
        .width_first  (width_first),
        .wrap_on_fall (wrap_on_fall),
        .cap_en       (cap_en),
        .flag_clr     (flag_clr),
        .err_clr      (err_clr),
        .cap0         (cap0),
        .cap1         (cap1),
        .cap_flag     (cap_flag),
        .overrun_err  (overrun_err)
    );

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sig_in = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic pulse(input int hi, input int lo);
        sig_in = 1'b1;
        wait_n(hi);
        sig_in = 1'b0;
        wait_n(lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1", "cap0", int'(cap0), 0);
        chk("R1", "cap1", int'(cap1), 0);
        chk("R1", "flags", int'(cap_flag), 0);
        chk("R1", "err", int'(overrun_err), 0);

        // R2 R3 R4 sweep with flags cleared continuously
        for (int sw = 0; sw < 2; sw++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int hi = 1; hi <= 5; hi++) begin
                    for (int lo = 1; lo <= 5; lo++) begin
                        int per;
                        int wid;
                        width_first  = sw[0];
                        wrap_on_fall = inv[0];
                        cap_en   = 2'b11;
                        flag_clr = 2'b11;
                        do_reset();
                        pulse(hi, lo);
                        pulse(hi, lo);
                        sig_in = 1'b1;
                        wait_n(8);
                        per = hi + lo;
                        wid = (inv != 0) ? lo : hi;
                        chk(sw != 0 ? "R3" : "R2", inv != 0 ? "R4 cap0" : "cap0",
                            int'(cap0), (sw != 0) ? wid : per);
                        chk(sw != 0 ? "R3" : "R2", inv != 0 ? "R4 cap1" : "cap1",
                            int'(cap1), (sw != 0) ? per : wid);
                        chk("R7", "sweep err", int'(overrun_err), 0);
                    end
                end
            end
        end
        flag_clr = 2'b00;

        // R5 opposite edge and first restart edge capture nothing
        width_first = 1'b0;
        wrap_on_fall = 1'b1;
        cap_en = 2'b11;
        do_reset();
        sig_in = 1'b1;
        wait_n(6);
        chk("R5", "flags after early edge", int'(cap_flag), 0);
        sig_in = 1'b0;
        wait_n(6);
        chk("R5", "flags after first restart", int'(cap_flag), 0);
        chk("R5", "cap0", int'(cap0), 0);

        // R6 channel 1 disabled
        wrap_on_fall = 1'b0;
        cap_en = 2'b01;
        do_reset();
        pulse(3, 4);
        sig_in = 1'b1;
        wait_n(6);
        chk("R6", "cap0", int'(cap0), 7);
        chk("R6", "cap1", int'(cap1), 0);
        chk("R6", "flags", int'(cap_flag), 1);

        // R7 overrun drops new values
        cap_en = 2'b11;
        do_reset();
        pulse(2, 3);
        pulse(5, 3);
        wait_n(5);
        chk("R7", "cap0", int'(cap0), 5);
        chk("R7", "cap1", int'(cap1), 2);
        chk("R7", "err", int'(overrun_err), 1);
        chk("R7", "flags", int'(cap_flag), 3);

        // R9 error clear leaves flags alone
        err_clr = 1'b1;
        wait_n(1);
        err_clr = 1'b0;
        wait_n(1);
        chk("R9", "err", int'(overrun_err), 0);
        chk("R9", "flags", int'(cap_flag), 3);

        // R8 plain clear
        flag_clr = 2'b01;
        wait_n(1);
        flag_clr = 2'b00;
        wait_n(1);
        chk("R8", "flags after clear", int'(cap_flag), 2);

        // R8 capture coinciding with clear
        do_reset();
        sig_in = 1'b1;
        wait_n(2);
        sig_in = 1'b0;
        wait_n(3);
        sig_in = 1'b1;
        wait_n(6);
        chk("R8", "cap1 before", int'(cap1), 2);
        sig_in = 1'b0;
        wait_n(2);
        flag_clr = 2'b10;
        wait_n(1);
        flag_clr = 2'b00;
        wait_n(3);
        chk("R8", "cap1 written", int'(cap1), 6);
        chk("R8", "flag1 kept", int'(cap_flag[1]), 1);
        chk("R8", "no err", int'(overrun_err), 0);

        // R10 saturation
        cap_en = 2'b11;
        flag_clr = 2'b11;
        do_reset();
        pulse(70, 10);
        sig_in = 1'b1;
        wait_n(6);
        chk("R10", "period sat", int'(cap0), CMAX);
        chk("R10", "width sat", int'(cap1), CMAX);
        flag_clr = 2'b00;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule